// File: doc/BRIEF.md
# Oscillator Settling Timer

This block manages the start-up of one oscillator source. Software starts the source by setting an enable bit. The block raises a run request toward the oscillator and then counts reference ticks for a programmable settling interval. Only after that interval does it declare the clock usable, by asserting a ready qualifier and setting a sticky completion flag. Software clears the flag by writing 1.

A per-source sleep policy bit decides what happens in deep sleep.

- With the policy set, the run request is withdrawn while the chip sleeps. The source is therefore unstable on wake-up, and the block runs a fresh settling interval before ready returns.
- With the policy clear, the source keeps running through sleep, ready stays up, and no new interval starts.

The oscillator itself is modelled only as the run request. Reference ticks arrive on a single-cycle strobe.

Top module: `osc_settle_timer`

## Requirements
- R1: After reset, `clk_ready`, `irq_flag` and `osc_run` are all 0.
- R2: `osc_run` is 1 exactly when `osc_en` is 1 and not both `sleep_stop` and `deep_sleep` are 1; it follows these inputs in the same cycle.
- R3: A rising edge of `osc_run` starts a settling interval of 2^(code+4) reference ticks, where code is the 3-bit `wait_sel` value (code 0 gives 16 ticks, code 7 gives 2048). Ticks are counted from the cycle after the start cycle. Cycles without `ref_tick` do not advance the count. `clk_ready` stays 0 until the last tick of the interval and is 1 from the cycle after that tick.
- R4: `irq_flag` becomes 1 in the cycle after each completed interval and otherwise holds its value.
- R5: A cycle with `irq_clr` = 1 clears `irq_flag`. If that cycle also completes an interval, the flag is 1 afterwards.
- R6: Clearing `osc_en` drops `clk_ready` in the same cycle and abandons any interval in progress. Setting it again runs a complete new interval.
- R7: With `sleep_stop` = 1, entering deep sleep drops `clk_ready` and `osc_run`. On wake-up a complete new interval runs, and `irq_flag` is set again at its end.
- R8: With `sleep_stop` = 0, deep sleep leaves `osc_run` and `clk_ready` at 1 and starts no new interval, so `irq_flag` is not set again.
- R9: The `wait_sel` value is captured at the start of an interval. A change during the interval affects only the next start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| osc_en | input | 1 | Oscillator enable from software |
| wait_sel | input | 3 | Settling interval code |
| sleep_stop | input | 1 | 1: stop the source in deep sleep |
| deep_sleep | input | 1 | Chip is in deep sleep |
| ref_tick | input | 1 | One-cycle reference tick strobe |
| irq_clr | input | 1 | Write-1-to-clear strobe for the flag |
| osc_run | output | 1 | Run request to the oscillator |
| clk_ready | output | 1 | Clock is settled and usable |
| irq_flag | output | 1 | Sticky settling-complete flag |

## Verification
Two functions can fall in the same cycle: completing the settling interval sets the flag, and a write-1 strobe clears it. The bench first clears the flag. It then lines up `irq_clr` with the very tick that ends an interval, and requires the flag to read 1 on the following cycle. A separate clear with no completion must then return the flag to 0. This shows that the set won the collision and was not just a flag that never cleared.

// File: rtl/osc_settle_pkg.sv
package osc_settle_pkg;

  // Number of reference ticks for a settling code: 2^(code+base).
  function automatic logic [31:0] settle_ticks(input logic [31:0] code,
                                               input logic [31:0] base);
    return 32'd1 << (code + base);
  endfunction

endpackage

// File: rtl/osc_settle_counter.sv
module osc_settle_counter
  import osc_settle_pkg::*;
#(
  parameter int SEL_W    = 3,
  parameter int BASE_EXP = 4,
  localparam int CNT_W   = BASE_EXP + (1 << SEL_W) - 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             run,
  input  logic             tick,
  input  logic [SEL_W-1:0] sel_in,
  output logic             done,
  output logic             busy
);

  logic             busy_q;
  logic [CNT_W-1:0] cnt_q;
  logic [SEL_W-1:0] sel_q;
  logic [CNT_W-1:0] last_cnt;

  assign last_cnt = CNT_W'(settle_ticks(32'(sel_q), 32'(BASE_EXP)) - 32'd1);
  assign done     = busy_q && run && !start && tick && (cnt_q == last_cnt);
  assign busy     = busy_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
      sel_q  <= '0;
    end else if (!run) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
    end else if (start) begin
      busy_q <= 1'b1;
      cnt_q  <= '0;
      sel_q  <= sel_in;
    end else if (busy_q && tick) begin
      if (done) begin
        busy_q <= 1'b0;
        cnt_q  <= '0;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  // R3: the count never passes the last tick of the captured interval
  p_cnt_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q |-> cnt_q <= last_cnt);

  // R3: completion ends the interval
  p_done_ends_r3: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !busy_q);

  // R9: captured code does not move while an interval runs
  p_sel_held_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && !start) |=> $stable(sel_q));

endmodule

// File: rtl/osc_settle_irq.sv
module osc_settle_irq (
  input  logic clk,
  input  logic rst_n,
  input  logic set_evt,
  input  logic clr_req,
  output logic flag
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        flag <= 1'b0;
    else if (set_evt)  flag <= 1'b1;
    else if (clr_req)  flag <= 1'b0;
  end

  // R5: completion in the clear cycle wins
  p_set_wins_r5: assert property (@(posedge clk) disable iff (!rst_n)
    set_evt |=> flag);

  // R5: a lone clear strobe empties the flag
  p_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_req && !set_evt) |=> !flag);

  // R4: no event, no change
  p_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!set_evt && !clr_req) |=> $stable(flag));

endmodule

// File: rtl/osc_settle_timer.sv
module osc_settle_timer #(
  parameter int SEL_W    = 3,
  parameter int BASE_EXP = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             osc_en,
  input  logic [SEL_W-1:0] wait_sel,
  input  logic             sleep_stop,
  input  logic             deep_sleep,
  input  logic             ref_tick,
  input  logic             irq_clr,
  output logic             osc_run,
  output logic             clk_ready,
  output logic             irq_flag
);

  logic run_q;
  logic ready_q;
  logic start_evt;
  logic done_evt;
  logic wait_busy;
  logic sleep_halt;

  assign sleep_halt = sleep_stop && deep_sleep;
  assign osc_run    = osc_en && !sleep_halt;
  assign start_evt  = osc_run && !run_q;
  assign clk_ready  = ready_q && osc_run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q   <= 1'b0;
      ready_q <= 1'b0;
    end else begin
      run_q <= osc_run;
      if (!osc_run)      ready_q <= 1'b0;
      else if (done_evt) ready_q <= 1'b1;
    end
  end

  osc_settle_counter #(
    .SEL_W   (SEL_W),
    .BASE_EXP(BASE_EXP)
  ) u_count (
    .clk   (clk),
    .rst_n (rst_n),
    .start (start_evt),
    .run   (osc_run),
    .tick  (ref_tick),
    .sel_in(wait_sel),
    .done  (done_evt),
    .busy  (wait_busy)
  );

  osc_settle_irq u_irq (
    .clk    (clk),
    .rst_n  (rst_n),
    .set_evt(done_evt),
    .clr_req(irq_clr),
    .flag   (irq_flag)
  );

  // R7: a (re)start always leaves the clock unusable first
  p_start_not_ready_r7: assert property (@(posedge clk) disable iff (!rst_n)
    start_evt |=> !clk_ready);

  // R3: ready is never up while the interval is still counting
  p_no_ready_in_wait_r3: assert property (@(posedge clk) disable iff (!rst_n)
    wait_busy |-> !clk_ready);

  // R3: completion makes the clock usable unless the source stopped
  p_ready_after_done_r3: assert property (@(posedge clk) disable iff (!rst_n)
    done_evt |=> (clk_ready || !osc_run));

  // R8: sleeping with policy 0 keeps a settled clock usable
  p_sleep_keep_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (clk_ready && !sleep_stop && osc_en) |=>
      (clk_ready || !osc_en || sleep_stop));

endmodule

// File: tb/osc_settle_timer_test.sv
module osc_settle_timer_test;

  localparam int CLK_PERIOD = 10;

  typedef struct packed {
    logic [2:0] sel;
    logic [7:0] gap;
  } vec_t;

  localparam int NVEC = 6;
  localparam vec_t VECS [NVEC] = '{
    '{sel: 3'd0, gap: 8'd0},
    '{sel: 3'd1, gap: 8'd2},
    '{sel: 3'd2, gap: 8'd0},
    '{sel: 3'd3, gap: 8'd1},
    '{sel: 3'd5, gap: 8'd0},
    '{sel: 3'd7, gap: 8'd0}
  };

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       osc_en = 1'b0;
  logic [2:0] wait_sel = 3'd0;
  logic       sleep_stop = 1'b0;
  logic       deep_sleep = 1'b0;
  logic       ref_tick = 1'b0;
  logic       irq_clr = 1'b0;
  logic       osc_run, clk_ready, irq_flag;

  int n_chk = 0;
  int n_bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  osc_settle_timer uut (
    .clk(clk), .rst_n(rst_n), .osc_en(osc_en), .wait_sel(wait_sel),
    .sleep_stop(sleep_stop), .deep_sleep(deep_sleep), .ref_tick(ref_tick),
    .irq_clr(irq_clr), .osc_run(osc_run), .clk_ready(clk_ready),
    .irq_flag(irq_flag)
  );

  function automatic int ticks_for(input int code);
    int n = 16;
    for (int i = 0; i < code; i++) n = n * 2;
    return n;
  endfunction

  task automatic check(input string req, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic tick_once(input int gap, input logic clr = 1'b0);
    @(negedge clk);
    ref_tick = 1'b1;
    irq_clr  = clr;
    @(negedge clk);
    ref_tick = 1'b0;
    irq_clr  = 1'b0;
    repeat (gap) @(negedge clk);
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) tick_once(0);
  endtask

  task automatic clear_flag();
    @(negedge clk);
    irq_clr = 1'b1;
    @(negedge clk);
    irq_clr = 1'b0;
  endtask

  task automatic report();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    report();
  end

  initial begin
    int lim;
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 ready", clk_ready, 1'b0);
    check("R1 flag", irq_flag, 1'b0);
    check("R1 run", osc_run, 1'b0);
    rst_n = 1'b1;
    @(negedge clk);

    // R3 / R4 table walk
    for (int v = 0; v < NVEC; v++) begin
      lim = ticks_for(int'(VECS[v].sel));
      wait_sel = VECS[v].sel;
      osc_en = 1'b1;
      #1 check("R2 run on enable", osc_run, 1'b1);
      @(negedge clk);
      for (int k = 1; k < lim; k++) tick_once(int'(VECS[v].gap));
      check("R3 not ready before last tick", clk_ready, 1'b0);
      check("R4 flag not early", irq_flag, 1'b0);
      tick_once(0);
      check("R3 ready after last tick", clk_ready, 1'b1);
      check("R4 flag set", irq_flag, 1'b1);
      osc_en = 1'b0;
      #1 check("R6 ready drops with enable", clk_ready, 1'b0);
      clear_flag();
      check("R5 flag cleared", irq_flag, 1'b0);
    end

    // R5 collision: clear strobe in the completing cycle
    wait_sel = 3'd0;
    osc_en = 1'b1;
    @(negedge clk);
    ticks(15);
    tick_once(0, 1'b1);
    check("R5 set wins over clear", irq_flag, 1'b1);
    clear_flag();
    check("R5 lone clear after collision", irq_flag, 1'b0);

    // R8 sleep with policy 0: stays ready, no new interval
    sleep_stop = 1'b0;
    deep_sleep = 1'b1;
    #1 check("R8 run kept in sleep", osc_run, 1'b1);
    ticks(20);
    check("R8 ready kept in sleep", clk_ready, 1'b1);
    deep_sleep = 1'b0;
    ticks(20);
    check("R8 ready after wake", clk_ready, 1'b1);
    check("R8 no new flag", irq_flag, 1'b0);

    // R7 sleep with policy 1: stop, then full interval on wake
    sleep_stop = 1'b1;
    @(negedge clk);
    deep_sleep = 1'b1;
    #1 check("R7 ready drops in sleep", clk_ready, 1'b0);
    check("R7 run drops in sleep", osc_run, 1'b0);
    ticks(3);
    deep_sleep = 1'b0;
    @(negedge clk);
    ticks(15);
    check("R7 not ready before rewait done", clk_ready, 1'b0);
    tick_once(0);
    check("R7 ready after rewait", clk_ready, 1'b1);
    check("R7 flag set again", irq_flag, 1'b1);
    clear_flag();
    sleep_stop = 1'b0;

    // R6 abort mid-wait, then full restart
    osc_en = 1'b0;
    @(negedge clk);
    osc_en = 1'b1;
    @(negedge clk);
    ticks(10);
    osc_en = 1'b0;
    @(negedge clk);
    osc_en = 1'b1;
    @(negedge clk);
    ticks(10);
    check("R6 restart needs full interval", clk_ready, 1'b0);
    ticks(5);
    check("R6 still waiting at 15", clk_ready, 1'b0);
    tick_once(0);
    check("R6 ready after full interval", clk_ready, 1'b1);
    clear_flag();

    // R9 code change mid-wait has no effect on current interval
    osc_en = 1'b0;
    wait_sel = 3'd0;
    @(negedge clk);
    osc_en = 1'b1;
    @(negedge clk);
    ticks(4);
    wait_sel = 3'd3;
    ticks(11);
    check("R9 not ready at 15", clk_ready, 1'b0);
    tick_once(0);
    check("R9 old code used", clk_ready, 1'b1);
    // next start uses the new code (128 ticks)
    osc_en = 1'b0;
    @(negedge clk);
    osc_en = 1'b1;
    @(negedge clk);
    ticks(127);
    check("R9 new code on next start, early", clk_ready, 1'b0);
    tick_once(0);
    check("R9 new code on next start", clk_ready, 1'b1);

    report();
  end

endmodule